// File: doc/BRIEF.md
# Binary Segment Link Tracker

This block takes a snapshot of segment hits from a cylindrical drift chamber. The snapshot has ten radial superlayers, and each superlayer is split into 32 azimuthal supercells. The block reports which supercells hold a track that was linked outward from the innermost superlayer.

A supercell in superlayer k+1 stays alive only if two things hold. It must carry a hit, and at least one supercell of superlayer k inside a small azimuthal window around the same index must still be alive. A per-cell mask can force dead or inefficient cells to read as hit. A per-transition select sets the window for each step. The window is three cells wide, or five cells wide for transitions between stereo superlayers.

Two 32-bit words come out. One marks tracks that reach the middle superlayer. The other marks tracks that reach the outermost superlayer. The linking chain is registered once per transition, so a new snapshot can enter on every clock.

Top module: `seg_link_tracker`

## Requirements
- R1: While rst_ni is low, and after it rises until the first event completes, valid_o is 0. mid_o and outer_o read 0 while reset is held.
- R2: Bit k*32+c of seg_i and mask_i belongs to superlayer k, supercell c. Superlayer 0 is the innermost.
- R3: A cell counts as hit when its seg_i bit or its mask_i bit is 1. The alive set of superlayer 0 equals its hit set.
- R4: When win_sel_i bit t is 0, supercell c of superlayer t+1 is alive only if it is hit and one of supercells c-1, c, c+1 of superlayer t is alive.
- R5: When win_sel_i bit t is 1, the window for the transition from superlayer t to t+1 widens to supercells c-2..c+2.
- R6: Window indices wrap modulo 32, so supercell 0 and supercell 31 are neighbours.
- R7: mid_o bit c is the alive state of supercell c in superlayer 4, the fifth. outer_o bit c is the alive state of supercell c in superlayer 9, the tenth.
- R8: A mask bit set to 1 lets a cell with no segment hit carry a track through.
- R9: When valid_i is high at a rising edge, valid_o is high for exactly one cycle after the ninth rising edge, counting that edge as the first. The result words are valid in that same cycle. Events on consecutive cycles each produce their own result.
- R10: win_sel_i is captured together with the event. Changes to it on later cycles do not affect an event already inside the chain.
- R11: A supercell is alive only if it is hit. A nonzero outer_o is always accompanied by a nonzero mid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Event present on seg_i, mask_i and win_sel_i |
| seg_i | input | 320 | Segment hit map, superlayer-major |
| mask_i | input | 320 | Force-hit mask, same layout as seg_i |
| win_sel_i | input | 9 | Window select per transition, 1 = five cells wide |
| valid_o | output | 1 | Result words valid |
| mid_o | output | 32 | Tracks reaching the middle superlayer |
| outer_o | output | 32 | Tracks reaching the outermost superlayer |

## Verification
The hardest case to reach is a track that survives all nine transitions. Random maps rarely produce one at low density, and they never pick out one particular window width or wrap-around.

The stimulus handles this in two ways. Directed single-cell paths drift by one or two cells per superlayer, and some cross the 31/0 seam in both directions. A select pattern that is wide on only the first few transitions pins down which select bit governs which step. Dense random maps with a sparse random mask and a select that changes every cycle then keep events overlapping in the chain while the configuration moves under them.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int unsigned LT_N_SL   = 10;
  localparam int unsigned LT_N_CELL = 32;
  localparam int unsigned LT_MID_SL = 4;
endpackage

// File: rtl/lt_delay.sv
module lt_delay #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned DEPTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] d_o
);
  logic [WIDTH-1:0] q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_s
    if (s == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q[s] <= '0;
        else         q[s] <= d_i;
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q[s] <= '0;
        else         q[s] <= q[s-1];
    end
  end

  assign d_o = q[DEPTH-1];
endmodule

// File: rtl/lt_window.sv
module lt_window #(
  parameter int unsigned N_CELL = 32
) (
  input  logic [N_CELL-1:0] row_i,
  input  logic              wide_i,
  output logic [N_CELL-1:0] win_o
);
  for (genvar c = 0; c < N_CELL; c++) begin : g_c
    localparam int unsigned M1 = (c + N_CELL - 1) % N_CELL;
    localparam int unsigned P1 = (c + 1) % N_CELL;
    localparam int unsigned M2 = (c + N_CELL - 2) % N_CELL;
    localparam int unsigned P2 = (c + 2) % N_CELL;
    assign win_o[c] = row_i[M1] | row_i[c] | row_i[P1]
                    | (wide_i & (row_i[M2] | row_i[P2]));
  end
endmodule

// File: rtl/lt_stage.sv
module lt_stage #(
  parameter int unsigned N_CELL = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CELL-1:0] alive_i,
  input  logic [N_CELL-1:0] hit_i,
  input  logic              wide_i,
  output logic [N_CELL-1:0] alive_o
);
  logic [N_CELL-1:0] win;

  lt_window #(.N_CELL(N_CELL)) u_win (
    .row_i  (alive_i),
    .wide_i (wide_i),
    .win_o  (win)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) alive_o <= '0;
    else         alive_o <= win & hit_i;

  // R11
  alive_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alive_o & ~$past(hit_i)) == '0);

  // R11
  alive_needs_parent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alive_o != '0) |-> ($past(alive_i) != '0));
endmodule

// File: rtl/seg_link_tracker.sv
module seg_link_tracker
  import lt_pkg::*;
#(
  parameter int unsigned N_SL   = LT_N_SL,
  parameter int unsigned N_CELL = LT_N_CELL,
  parameter int unsigned MID_SL = LT_MID_SL
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [N_SL*N_CELL-1:0]   seg_i,
  input  logic [N_SL*N_CELL-1:0]   mask_i,
  input  logic [N_SL-2:0]          win_sel_i,
  output logic                     valid_o,
  output logic [N_CELL-1:0]        mid_o,
  output logic [N_CELL-1:0]        outer_o
);
  localparam int unsigned N_TR  = N_SL - 1;
  localparam int unsigned CNT_W = $clog2(N_SL + 1) + 1;

  logic [N_CELL-1:0] eff    [N_SL];
  logic [N_CELL-1:0] alive  [N_SL];
  logic [N_CELL-1:0] hit_at [N_SL];
  logic              wide_at[N_TR];

  for (genvar k = 0; k < N_SL; k++) begin : g_eff
    assign eff[k] = seg_i[k*N_CELL +: N_CELL] | mask_i[k*N_CELL +: N_CELL];
  end

  assign alive[0]  = eff[0];
  assign hit_at[0] = eff[0];

  for (genvar k = 1; k < N_SL; k++) begin : g_tr
    if (k == 1) begin : g_first
      assign hit_at[k]    = eff[k];
      assign wide_at[k-1] = win_sel_i[k-1];
    end else begin : g_later
      // align layer k hits and its select with the alive row arriving at stage k
      lt_delay #(.WIDTH(N_CELL), .DEPTH(k-1)) u_hd (
        .clk_i (clk_i), .rst_ni (rst_ni), .d_i (eff[k]), .d_o (hit_at[k])
      );
      lt_delay #(.WIDTH(1), .DEPTH(k-1)) u_wd (
        .clk_i (clk_i), .rst_ni (rst_ni), .d_i (win_sel_i[k-1]), .d_o (wide_at[k-1])
      );
    end

    lt_stage #(.N_CELL(N_CELL)) u_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .alive_i (alive[k-1]),
      .hit_i   (hit_at[k]),
      .wide_i  (wide_at[k-1]),
      .alive_o (alive[k])
    );
  end

  lt_delay #(.WIDTH(N_CELL), .DEPTH(N_SL-1-MID_SL)) u_mid (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (alive[MID_SL]), .d_o (mid_o)
  );

  lt_delay #(.WIDTH(1), .DEPTH(N_TR)) u_vld (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (valid_i), .d_o (valid_o)
  );

  assign outer_o = alive[N_SL-1];

  // checker: events in flight
  logic [CNT_W-1:0] inflight_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) inflight_q <= '0;
    else if (valid_i && !valid_o) inflight_q <= inflight_q + 1'b1;
    else if (!valid_i && valid_o) inflight_q <= inflight_q - 1'b1;

  // R9
  no_orphan_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (inflight_q != '0));

  // R9
  inflight_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q <= CNT_W'(N_TR));

  // R11
  outer_implies_mid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && outer_o != '0) |-> (mid_o != '0));
endmodule

// File: tb/tb_seg_link_tracker.sv
module tb_seg_link_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 9;
  localparam int NSL = 10;
  localparam int NC  = 32;
  localparam int W   = NSL * NC;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [W-1:0]  seg_i = '0;
  logic [W-1:0]  mask_i = '0;
  logic [NSL-2:0] win_sel_i = '0;
  logic          valid_o;
  logic [NC-1:0] mid_o, outer_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_link_tracker dut (
    .clk_i (clk), .rst_ni (rst_ni), .valid_i (valid_i), .seg_i (seg_i),
    .mask_i (mask_i), .win_sel_i (win_sel_i), .valid_o (valid_o),
    .mid_o (mid_o), .outer_o (outer_o)
  );

  int n_run = 0, n_fail = 0, m = 0;
  logic          rv   [16];
  logic [NC-1:0] rmid [16];
  logic [NC-1:0] rout [16];
  string         rtag [16];

  task automatic chk(string tag, logic ok, logic [NC-1:0] act, logic [NC-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [W-1:0] s, input logic [W-1:0] mk,
                                input logic [NSL-2:0] w,
                                output logic [NC-1:0] mid, output logic [NC-1:0] out);
    logic [W-1:0] e;
    logic [NC-1:0] a, nx;
    e = s | mk;
    a = e[NC-1:0];
    mid = '0;
    for (int k = 1; k < NSL; k++) begin
      nx = '0;
      for (int c = 0; c < NC; c++)
        for (int d = -2; d <= 2; d++)
          if (((d >= -1) && (d <= 1)) || w[k-1])
            if (a[(c + d + NC) % NC]) nx[c] = 1'b1;
      a = nx & e[k*NC +: NC];
      if (k == 4) mid = a;
    end
    out = a;
  endfunction

  function automatic logic [W-1:0] path(int c0, int d, int upto);
    logic [W-1:0] r = '0;
    int c = c0;
    for (int k = 0; k < NSL; k++) begin
      if (k > 0 && k <= upto) c += d;
      r[k*NC + (((c % NC) + NC) % NC)] = 1'b1;
    end
    return r;
  endfunction

  task automatic step(logic v, logic [W-1:0] s, logic [W-1:0] mk, logic [NSL-2:0] w,
                      string tag, logic [NC-1:0] emid, logic [NC-1:0] eout);
    int idx;
    @(negedge clk);
    if (m >= LAT) begin
      idx = (m - LAT) % 16;
      chk("R9 valid_o", valid_o == rv[idx], NC'(valid_o), NC'(rv[idx]));
      if (rv[idx]) begin
        chk({rtag[idx], " mid_o"}, mid_o == rmid[idx], mid_o, rmid[idx]);
        chk({rtag[idx], " outer_o"}, outer_o == rout[idx], outer_o, rout[idx]);
        if (outer_o != '0) chk("R11 mid with outer", mid_o != '0, mid_o, '1);
      end
    end
    valid_i = v; seg_i = s; mask_i = mk; win_sel_i = w;
    rv[m % 16] = v; rmid[m % 16] = emid; rout[m % 16] = eout; rtag[m % 16] = tag;
    m++;
  endtask

  task automatic send_dir(logic [W-1:0] s, logic [W-1:0] mk, logic [NSL-2:0] w,
                          string tag, logic [NC-1:0] emid, logic [NC-1:0] eout);
    step(1'b1, s, mk, w, tag, emid, eout);
  endtask

  task automatic idle(logic [NSL-2:0] w);
    step(1'b0, '0, '0, w, "idle", '0, '0);
  endtask

  function automatic logic [W-1:0] rnd_map(int dens);
    logic [W-1:0] r;
    for (int k = 0; k < NSL; k++) begin
      logic [NC-1:0] x;
      x = $urandom;
      if (dens >= 1) x |= $urandom;
      if (dens >= 2) x |= $urandom;
      if (dens < 0) x &= $urandom & $urandom;
      r[k*NC +: NC] = x;
    end
    return r;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [W-1:0] s, mk, p;
    logic [NSL-2:0] w;
    logic [NC-1:0] em, eo;
    void'($urandom(32'd20241));
    for (int i = 0; i < 16; i++) begin rv[i] = 1'b0; rmid[i] = '0; rout[i] = '0; rtag[i] = ""; end

    // R1 reset state, with live inputs
    seg_i = '1; mask_i = '1; valid_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 valid_o in reset", valid_o == 1'b0, NC'(valid_o), '0);
    chk("R1 mid_o in reset", mid_o == '0, mid_o, '0);
    chk("R1 outer_o in reset", outer_o == '0, outer_o, '0);
    valid_i = 1'b0; seg_i = '0; mask_i = '0;
    rst_ni = 1'b1;

    // R2 R4 narrow drift of one cell per layer
    send_dir(path(10, 1, 9), '0, '0, "R2 R4 drift1", 32'h1 << 14, 32'h1 << 19);
    // R4 drift of two cells breaks a narrow chain
    send_dir(path(10, 2, 9), '0, '0, "R4 drift2 narrow", '0, '0);
    // R5 R10 wide everywhere, select dropped next cycle
    send_dir(path(10, 2, 9), '0, 9'h1FF, "R5 R10 drift2 wide", 32'h1 << 18, 32'h1 << 28);
    idle('0);
    // R5 select bit t governs transition t->t+1
    send_dir(path(10, 2, 4), '0, 9'h00F, "R5 bits0-3 wide", 32'h1 << 18, 32'h1 << 18);
    send_dir(path(10, 2, 4), '0, 9'h007, "R5 bit3 narrow", '0, '0);
    // R6 wrap in both directions
    send_dir(path(30, 1, 9), '0, '0, "R6 wrap up", 32'h1 << 2, 32'h1 << 7);
    send_dir(path(1, -2, 9), '0, 9'h1FF, "R6 wrap down", 32'h1 << 25, 32'h1 << 15);
    // R8 mask alone carries a track
    send_dir('0, path(10, 1, 9), '0, "R8 mask only", 32'h1 << 14, 32'h1 << 19);
    p = path(10, 1, 9);
    p[6*NC + 16] = 1'b0;
    // R7 gap past the middle: mid only
    send_dir(p, '0, '0, "R7 gap layer6", 32'h1 << 14, '0);
    mk = '0; mk[6*NC + 16] = 1'b1;
    send_dir(p, mk, '0, "R8 mask fills gap", 32'h1 << 14, 32'h1 << 19);
    // R3 empty innermost layer kills everything
    s = '1; s[NC-1:0] = '0;
    send_dir(s, '0, 9'h1FF, "R3 empty layer0", '0, '0);
    // R2 R7 full map
    send_dir('1, '0, '0, "R2 R7 full map", '1, '1);
    repeat (LAT + 1) idle(9'($urandom));

    // random mix, select changing every cycle
    for (int i = 0; i < 600; i++) begin
      w = 9'($urandom);
      if ($urandom_range(0, 2) != 0) begin
        s  = rnd_map($urandom_range(0, 2));
        mk = rnd_map(-1);
        if ($urandom_range(0, 3) == 0) mk = '0;
        model(s, mk, w, em, eo);
        step(1'b1, s, mk, w, "R7 R10 random", em, eo);
      end else begin
        idle(w);
      end
    end
    repeat (LAT + 1) idle(9'($urandom));

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule